// File: doc/BRIEF.md
# Tile Writeback with Repeat-Tile Suppression

This block moves one finished screen tile from on-chip tile storage out to external memory, and leaves the write out when the tile has not changed. A tile is handled only once its rendering is done. The block takes every pixel word of the tile in raster order and computes a CRC-32 signature as the words arrive. It also copies each word into a local tile buffer. When the last word has been taken, the new signature is compared with the one stored for the same tile position during the frame before. If the two are equal, nothing is sent on the write stream. Otherwise the buffered words are streamed out, each with its word address.

By default a tile is 16×16 pixels and each pixel word is 256 bits wide. A signature table keeps one 32-bit entry per tile position, and two flags per entry record whether the signature was refreshed in the current frame and in the previous one. A frame-start pulse rolls the table over to a new frame. The new signature is stored after every finished tile, whether the tile was written or skipped.

Both data paths are valid/ready streams. On the input side a word moves on a clock edge where `pix_valid` and `pix_ready` are both high, and the source may hold `pix_valid` low for as long as it likes. On the output side the sink may hold `wr_ready` low for any number of cycles. The block keeps the current beat unchanged until that beat is taken. The control inputs (`start`, `frame_start`) and the status outputs are plain single-cycle signals.

Top module: `tile_wb_elide`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pix_ready`, `wr_valid` and `done` are low.
- R2: `start` is taken only while the block is idle, and it latches `tile_idx`. `pix_ready` then stays high until NPIX = TILE_DIM² words have been accepted, and it is low from the cycle after the last accepted word.
- R3: The signature is reflected CRC-32: polynomial 0xEDB88320, initial value 0xFFFFFFFF, result inverted. Within each word, bit 0 is fed first; words are fed in acceptance order. The signature appears on `sig_out`, with a one-cycle `done` pulse, in the cycle after the last word is accepted. `sig_out` holds its value until the next `done`.
- R4: The first time a tile position finishes after reset, it reports `skipped` = 0 and is written.
- R5: A tile reports `skipped` = 1 when its position had a signature stored during the previous frame and that signature equals the new one. In that case `wr_valid` stays low.
- R6: A tile that is not skipped raises `wr_valid` in the same cycle as `done`, then sends NPIX beats. Beat n carries the n-th accepted word, `wr_addr` = tile_idx·NPIX + n, and `wr_last` is set on beat NPIX−1 only. After that beat `wr_valid` drops.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_last` stay unchanged.
- R8: The signature of every finished tile is stored for its position, whether the tile was written or skipped. A later frame is therefore compared against the latest content.
- R9: A `frame_start` pulse makes only the signatures stored during the frame that just ended eligible for matching. A position that was not finished in the previous frame is written even if its content is unchanged.
- R10: `start` asserted while a tile is loading or writing is ignored. The tile in progress keeps its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| start | input | 1 | Begin a tile; taken only when idle |
| tile_idx | input | $clog2(NUM_TILES) | Tile position, latched on start |
| pix_valid | input | 1 | Input word valid |
| pix_ready | output | 1 | Block accepts an input word |
| pix_data | input | PIX_W | Pixel word from tile storage |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Sink takes the write beat |
| wr_addr | output | $clog2(NUM_TILES)+$clog2(NPIX) | Word address of the beat |
| wr_data | output | PIX_W | Pixel word to external memory |
| wr_last | output | 1 | Final beat of the tile |
| done | output | 1 | One-cycle pulse: signature and decision ready |
| skipped | output | 1 | Decision for the last tile: 1 = write suppressed |
| sig_out | output | 32 | Signature of the last finished tile |

## Verification
The properties assume that a source and sink obeying the handshake rules above drive the two streams. They also assume that `frame_start` and `start` arrive only while the block is idle, so a table rollover never falls in the same cycle as a tile completion. The stimulus issues `frame_start` only between tiles, and it pulses a stray `start` only in the middle of a load, where it must be ignored. Input bubbles and stalls on `wr_ready` follow fixed arithmetic patterns. A small configuration is swept: four tiles of four 16-bit words over six frames. Across those frames some tiles change, one keeps its content, one changes every frame and one is left out for a frame.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WRITE} twb_state_e;

  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  // one serial step of the reflected CRC-32 register
  function automatic logic [31:0] crc_shift(input logic [31:0] c, input logic b);
    crc_shift = (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_R : 32'h0);
  endfunction
endpackage

// File: rtl/twb_crc.sv
module twb_crc #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] data,
  output logic [31:0]  fin_next
);
  import twb_pkg::*;

  logic [31:0] acc_q;
  logic [31:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    for (int i = 0; i < W; i++) acc_d = crc_shift(acc_d, data[i]);
  end

  assign fin_next = ~acc_d;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= CRC_SEED;
    else if (clear) acc_q <= CRC_SEED;
    else if (en)    acc_q <= acc_d;
  end
endmodule

// File: rtl/twb_sig_table.sv
module twb_sig_table #(
  parameter int NUM_TILES = 16,
  localparam int IW = $clog2(NUM_TILES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [31:0]   upd_sig,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_ok,
  output logic [31:0]   rd_sig
);
  logic [31:0]          sig_mem [NUM_TILES];
  logic [NUM_TILES-1:0] prev_q;
  logic [NUM_TILES-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      cur_q  <= '0;
    end else begin
      if (frame_start) begin
        prev_q <= cur_q;
        cur_q  <= '0;
      end
      if (upd_en) cur_q[upd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) sig_mem[upd_idx] <= upd_sig;
  end

  assign rd_ok  = prev_q[rd_idx];
  assign rd_sig = sig_mem[rd_idx];
endmodule

// File: rtl/twb_tile_buf.sv
module twb_tile_buf #(
  parameter int W     = 256,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tile_wb_elide.sv
module tile_wb_elide #(
  parameter int PIX_W     = 256,
  parameter int TILE_DIM  = 16,
  parameter int NUM_TILES = 16,
  localparam int NPIX     = TILE_DIM * TILE_DIM,
  localparam int IW       = $clog2(NUM_TILES),
  localparam int CW       = $clog2(NPIX),
  localparam int AW       = IW + CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             start,
  input  logic [IW-1:0]    tile_idx,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic             wr_last,
  output logic             done,
  output logic             skipped,
  output logic [31:0]      sig_out
);
  import twb_pkg::*;

  localparam logic [CW-1:0] CNT_LAST = CW'(NPIX - 1);

  twb_state_e  state_q;
  logic [IW-1:0] tile_q;
  logic [CW-1:0] cnt_q;
  logic          pix_fire, wr_fire, in_last, out_last, take_start;
  logic [31:0]   crc_fin;
  logic          tbl_ok;
  logic [31:0]   tbl_sig;
  logic          repeat_hit;

  assign pix_ready  = (state_q == ST_LOAD);
  assign wr_valid   = (state_q == ST_WRITE);
  assign pix_fire   = pix_valid && pix_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign in_last    = pix_fire && (cnt_q == CNT_LAST);
  assign out_last   = (cnt_q == CNT_LAST);
  assign take_start = (state_q == ST_IDLE) && start;
  assign repeat_hit = tbl_ok && (tbl_sig == crc_fin);

  twb_crc #(.W(PIX_W)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take_start),
    .en       (pix_fire),
    .data     (pix_data),
    .fin_next (crc_fin)
  );

  twb_sig_table #(.NUM_TILES(NUM_TILES)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .upd_en      (in_last),
    .upd_idx     (tile_q),
    .upd_sig     (crc_fin),
    .rd_idx      (tile_q),
    .rd_ok       (tbl_ok),
    .rd_sig      (tbl_sig)
  );

  twb_tile_buf #(.W(PIX_W), .DEPTH(NPIX)) u_buf (
    .clk   (clk),
    .we    (pix_fire),
    .waddr (cnt_q),
    .wdata (pix_data),
    .raddr (cnt_q),
    .rdata (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tile_q  <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      skipped <= 1'b0;
      sig_out <= '0;
    end else begin
      done <= in_last;
      unique case (state_q)
        ST_IDLE: if (take_start) begin
          state_q <= ST_LOAD;
          tile_q  <= tile_idx;
          cnt_q   <= '0;
        end
        ST_LOAD: if (pix_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (in_last) begin
            sig_out <= crc_fin;
            skipped <= repeat_hit;
            state_q <= repeat_hit ? ST_IDLE : ST_WRITE;
            cnt_q   <= '0;
          end
        end
        ST_WRITE: if (wr_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (out_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_addr = {tile_q, cnt_q};
  assign wr_last = wr_valid && out_last;
endmodule

// File: rtl/twb_props.sv
module twb_props #(
  parameter int PIX_W = 256,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [AW-1:0]    wr_addr,
  input logic [PIX_W-1:0] wr_data,
  input logic             wr_last,
  input logic             done,
  input logic             skipped,
  input logic [31:0]      sig_out
);
  assert_one_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ready && wr_valid));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last));

  assert_done_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pix_valid && pix_ready));

  assert_sig_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sig_out));

  assert_input_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pix_ready);

  assert_skip_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && skipped |-> !wr_valid);

  assert_write_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !skipped |-> wr_valid);

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_last |=> !wr_valid);
endmodule

bind tile_wb_elide twb_props #(.PIX_W(PIX_W), .AW(AW)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_last   (wr_last),
  .done      (done),
  .skipped   (skipped),
  .sig_out   (sig_out)
);

// File: tb/tile_wb_elide_test.sv
module tile_wb_elide_test;
  localparam int PW = 16;
  localparam int TD = 2;
  localparam int NT = 4;
  localparam int NP = TD * TD;
  localparam int IW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] tile_idx = '0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [PW-1:0] pix_data = '0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;
  logic wr_last;
  logic done, skipped;
  logic [31:0] sig_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [31:0] m_sig [NT];
  logic        m_prev [NT];
  logic        m_cur [NT];

  tile_wb_elide #(.PIX_W(PW), .TILE_DIM(TD), .NUM_TILES(NT)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start(start),
    .tile_idx(tile_idx), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .done(done), .skipped(skipped), .sig_out(sig_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ver(input int t, input int f);
    case (t)
      0: ver = (f >= 4) ? 1 : 0;
      1: ver = 0;
      2: ver = ((f >= 1) ? 1 : 0) + ((f >= 4) ? 1 : 0);
      default: ver = f;
    endcase
  endfunction

  function automatic logic [PW-1:0] word_of(input int t, input int f, input int k);
    word_of = PW'(t * 16'h1111 + k * 16'h0203 + ver(t, f) * 16'h0F0F + 1);
  endfunction

  // R3 reference: reflected CRC-32, seed all ones, bit 0 first, inverted result
  function automatic logic [31:0] ref_crc(input int t, input int f);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < NP; k++) begin
      logic [PW-1:0] w = word_of(t, f, k);
      for (int b = 0; b < PW; b++) begin
        logic fb = c[0] ^ w[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic run_tile(input int t, input int f);
    logic [31:0] exp_sig;
    logic exp_skip;
    string dreq;
    int k = 0;
    int it = 0;
    int beats = 0;
    logic stalled = 1'b0;
    logic [AW-1:0] s_addr;
    logic [PW-1:0] s_data;
    logic s_last;
    exp_sig  = ref_crc(t, f);
    exp_skip = m_prev[t] && (m_sig[t] == exp_sig);
    if (f == 0) dreq = "R4";
    else if (f == 3 && t == 1) dreq = "R9";
    else dreq = "R5 R8";

    @(negedge clk);
    start = 1'b1;
    tile_idx = IW'(t);
    @(negedge clk);
    start = 1'b0;
    chk("R2 ready after start", 64'(pix_ready), 64'd1);
    while (k < NP) begin
      if (((f * 4 + t + k + it) % 3) == 0 && it[0] == 1'b0) begin
        pix_valid = 1'b0;
      end else begin
        pix_valid = 1'b1;
        pix_data = word_of(t, f, k);
      end
      // R10: stray start mid-load with another index
      if (k == 1 && it < 8) begin
        start = 1'b1;
        tile_idx = IW'((t + 1) % NT);
      end
      if (pix_valid && pix_ready) k = k + 1;
      it = it + 1;
      @(negedge clk);
      start = 1'b0;
    end
    pix_valid = 1'b0;
    chk("R3 done pulse", 64'(done), 64'd1);
    chk("R3 signature", 64'(sig_out), 64'(exp_sig));
    chk({dreq, " skipped"}, 64'(skipped), 64'(exp_skip));
    chk("R2 ready closed", 64'(pix_ready), 64'd0);
    m_sig[t] = exp_sig;
    m_cur[t] = 1'b1;

    if (exp_skip) begin
      chk("R5 no write on skip", 64'(wr_valid), 64'd0);
      @(negedge clk);
      chk("R5 still silent", 64'(wr_valid), 64'd0);
      chk("R3 done is one cycle", 64'(done), 64'd0);
    end else begin
      chk("R6 write starts with done", 64'(wr_valid), 64'd1);
      it = 0;
      while (beats < NP) begin
        wr_ready = ((f + t + it) % 3) != 0;
        if (stalled) begin
          chk("R7 stall hold", {wr_valid, wr_last, 46'(wr_addr), wr_data},
              {1'b1, s_last, 46'(s_addr), s_data});
        end
        if (wr_valid && wr_ready) begin
          chk("R6 addr R10 index kept", 64'(wr_addr), 64'(t * NP + beats));
          chk("R6 data", 64'(wr_data), 64'(word_of(t, f, beats)));
          chk("R6 last", 64'(wr_last), 64'(beats == NP - 1));
          beats = beats + 1;
          stalled = 1'b0;
        end else begin
          stalled = wr_valid;
          s_addr = wr_addr;
          s_data = wr_data;
          s_last = wr_last;
        end
        it = it + 1;
        @(negedge clk);
      end
      wr_ready = 1'b0;
      chk("R6 valid drops after last", 64'(wr_valid), 64'd0);
    end
  endtask

  task automatic new_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int t = 0; t < NT; t++) begin
      m_prev[t] = m_cur[t];
      m_cur[t] = 1'b0;
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin
      m_prev[t] = 1'b0;
      m_cur[t] = 1'b0;
      m_sig[t] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(pix_ready), 64'd0);
    chk("R1 wr_valid in reset", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(pix_ready), 64'd0);
    chk("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    for (int f = 0; f < 6; f++) begin
      new_frame();
      for (int t = 0; t < NT; t++) begin
        if (!(f == 2 && t == 1)) run_tile(t, f);
      end
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule